// File: doc/BRIEF.md
# Multiplexed Address/Data Host Bus Slave

This block sits between a narrow parallel host bus and the 32-bit register and FIFO fabric of a chip. The host first places an address on the shared `ad` lines and pulses an address strobe. It then moves data in narrow pieces under read or write strobes. The block turns each group of narrow cycles into one 32-bit access on its internal side. All strobes are sampled on the system clock as single-cycle pulses.

The bus width can be 8 or 16 bits. The address can be loaded in one phase, with the whole address on the bus, or in two phases, with a low-part strobe and a high-part strobe. Three byte orderings are selectable.

Addresses inside a fixed FIFO window behave as a port. The latched address stays in place, so the host can stream any number of dwords after a single address phase. Addresses outside that window accept exactly one dword per address phase.

Top module: `madb_slave`

## Requirements
- R1: After reset, `ad_o` is 0 and `acc_req_o` is low. Read and write strobes do nothing until an address phase has taken place.
- R2: With `dual_i`=0, `ale_lo_i` loads the whole dword address from `ad_i[ADDR_W-1:0]`. Bus bits above that are dropped, and `ale_hi_i` has no effect.
- R3: With `dual_i`=1, `ale_lo_i` loads address bits `[ADDR_W/2-1:0]` from the bottom of `ad_i`. `ale_hi_i` loads the remaining upper address bits from the bottom of `ad_i`. Each strobe leaves the other part unchanged.
- R4: In 16-bit mode (`wide_i`=1), a dword write takes two write strobes. The cycle of the second strobe shows `acc_req_o`=1, `acc_we_o`=1, the latched address and the assembled dword.
- R5: In 8-bit mode (`wide_i`=0), a dword takes four strobes, each carrying `ad_i[7:0]`. On reads, `ad_o[15:8]` is 0.
- R6: A read issues `acc_req_o`=1, `acc_we_o`=0 in the cycle of the first read strobe of a dword, and it samples `acc_rdata_i` in that cycle. The piece for the n-th read strobe of the dword appears on `ad_o` one cycle after that strobe. `ad_o` then holds until the next accepted read strobe.
- R7: `order_i` selects the byte order (00 little, 01 big, 10 mixed, 11 treated as little). Let stream byte j be the j-th byte moved on the bus, with the low byte of a 16-bit cycle first. Stream byte j maps to dword byte j for little, byte 3-j for big, and byte j XOR 2 for mixed.
- R8: An address strobe in the middle of a dword drops the partial dword with no access. The next data strobe starts a fresh dword.
- R9: For an address outside the FIFO window, once a dword has completed, further data strobes are ignored until a new address phase.
- R10: For a dword address in `[FIFO_BASE, FIFO_BASE+FIFO_NUM-1]`, data strobes keep being accepted after each completed dword. Every access uses the same latched address.
- R11: A read and a write strobe in the same cycle are both ignored. So is a strobe whose direction differs from the one that began the current partial dword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| dual_i | input | 1 | 1: two-phase address load |
| order_i | input | 2 | Byte order select |
| ale_lo_i | input | 1 | Address strobe (low part in two-phase mode) |
| ale_hi_i | input | 1 | High-part address strobe |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ad_i | input | 16 | Shared address/data lines, host to block |
| ad_o | output | 16 | Read data lines, block to host |
| acc_req_o | output | 1 | Internal 32-bit access request |
| acc_we_o | output | 1 | Access is a write |
| acc_addr_o | output | ADDR_W | Dword address of the access |
| acc_wdata_o | output | 32 | Write dword |
| acc_rdata_i | input | 32 | Read dword, valid in the request cycle |

## Verification
The bench uses the defaults: ADDR_W=12, FIFO_BASE=16 and FIFO_NUM=4. It can therefore reach both halves of a two-phase address, which are 6 bits each, and it can land on both sides of the FIFO window boundary. The bench also switches bus width, address mode and byte order at run time. This exercises every pairing of width and ordering on reads and writes. It also covers aborts, idle strobes after a register dword, and multi-dword bursts on a FIFO port. The read source returns a different dword on each pop, so a burst that repeated or skipped a read would show on `ad_o`.

// File: rtl/madb_pkg.sv
package madb_pkg;

  typedef enum logic [1:0] {
    ORD_LITTLE = 2'b00,
    ORD_BIG    = 2'b01,
    ORD_MIXED  = 2'b10,
    ORD_RSVD   = 2'b11
  } order_e;

  // maps between transfer stream and dword; each case is its own inverse
  function automatic logic [31:0] reorder(input logic [31:0] d, input order_e o);
    case (o)
      ORD_BIG:   reorder = {d[7:0], d[15:8], d[23:16], d[31:24]};
      ORD_MIXED: reorder = {d[15:0], d[31:16]};
      default:   reorder = d;
    endcase
  endfunction

endpackage

// File: rtl/madb_addr_latch.sv
module madb_addr_latch #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dual_i,
  input  logic              ale_lo_i,
  input  logic              ale_hi_i,
  input  logic [15:0]       ad_i,
  output logic              ale_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HALF = ADDR_W / 2;
  localparam int UPPER = ADDR_W - HALF;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (!dual_i) begin
      if (ale_lo_i) addr_q <= ad_i[ADDR_W-1:0];
    end else begin
      if (ale_lo_i) addr_q[HALF-1:0] <= ad_i[HALF-1:0];
      if (ale_hi_i) addr_q[ADDR_W-1:HALF] <= ad_i[UPPER-1:0];
    end
  end

  assign ale_o  = ale_lo_i | (dual_i & ale_hi_i);
  assign addr_o = addr_q;
endmodule

// File: rtl/madb_lane_seq.sv
module madb_lane_seq #(
  parameter int ADDR_W    = 12,
  parameter int FIFO_BASE = 16,
  parameter int FIFO_NUM  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              ale_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        cnt_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic              req_o,
  output logic              we_o
);
  logic [1:0] cnt_q;
  logic       armed_q;
  logic       dir_wr_q;
  logic [ADDR_W-1:0] fifo_off;
  logic       in_fifo;
  logic       last;
  logic       dir_ok;

  assign fifo_off = addr_i - ADDR_W'(FIFO_BASE);
  assign in_fifo  = fifo_off < ADDR_W'(FIFO_NUM);
  assign last     = wide_i ? (cnt_q == 2'd1) : (cnt_q == 2'd3);
  assign dir_ok   = (cnt_q == 2'd0) | (dir_wr_q == wr_i);

  assign rd_ok_o = armed_q & ~ale_i & rd_i & ~wr_i & dir_ok;
  assign wr_ok_o = armed_q & ~ale_i & wr_i & ~rd_i & dir_ok;
  assign we_o    = wr_ok_o & last;
  assign req_o   = we_o | (rd_ok_o & (cnt_q == 2'd0));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      dir_wr_q <= 1'b0;
    end else if (ale_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (rd_ok_o | wr_ok_o) begin
      dir_wr_q <= wr_ok_o;
      if (last) begin
        cnt_q   <= '0;
        armed_q <= in_fifo;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/madb_pack.sv
module madb_pack
  import madb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wide_i,
  input  logic [1:0]  order_i,
  input  logic [1:0]  cnt_i,
  input  logic        rd_ok_i,
  input  logic        wr_ok_i,
  input  logic [15:0] ad_i,
  input  logic [31:0] rdata_i,
  output logic [15:0] ad_o,
  output logic [31:0] wdata_o
);
  order_e      ord;
  logic [23:0] wbuf_q;
  logic [31:0] rhold_q;
  logic [31:0] rd_src;
  logic [15:0] piece;
  logic [4:0]  bsel;
  logic [4:0]  hsel;

  assign ord    = order_e'(order_i);
  assign rd_src = (cnt_i == 2'd0) ? reorder(rdata_i, ord) : rhold_q;
  assign bsel   = {cnt_i, 3'b000};
  assign hsel   = {cnt_i[0], 4'b0000};
  assign piece  = wide_i ? rd_src[hsel +: 16] : {8'h00, rd_src[bsel +: 8]};

  assign wdata_o = reorder(wide_i ? {ad_i, wbuf_q[15:0]} : {ad_i[7:0], wbuf_q}, ord);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbuf_q  <= '0;
      rhold_q <= '0;
      ad_o    <= '0;
    end else begin
      if (wr_ok_i) begin
        if (wide_i) begin
          if (cnt_i == 2'd0) wbuf_q[15:0] <= ad_i;
        end else if (cnt_i != 2'd3) begin
          wbuf_q[bsel +: 8] <= ad_i[7:0];
        end
      end
      if (rd_ok_i) begin
        if (cnt_i == 2'd0) rhold_q <= rd_src;
        ad_o <= piece;
      end
    end
  end
endmodule

// File: rtl/madb_slave.sv
module madb_slave #(
  parameter int ADDR_W    = 12,
  parameter int FIFO_BASE = 16,
  parameter int FIFO_NUM  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              dual_i,
  input  logic [1:0]        order_i,
  input  logic              ale_lo_i,
  input  logic              ale_hi_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [15:0]       ad_i,
  output logic [15:0]       ad_o,
  output logic              acc_req_o,
  output logic              acc_we_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [31:0]       acc_wdata_o,
  input  logic [31:0]       acc_rdata_i
);
  logic       ale;
  logic [1:0] cnt;
  logic       rd_ok;
  logic       wr_ok;

  madb_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .dual_i(dual_i),
    .ale_lo_i(ale_lo_i), .ale_hi_i(ale_hi_i), .ad_i(ad_i),
    .ale_o(ale), .addr_o(acc_addr_o)
  );

  madb_lane_seq #(.ADDR_W(ADDR_W), .FIFO_BASE(FIFO_BASE), .FIFO_NUM(FIFO_NUM)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i), .ale_i(ale),
    .rd_i(rd_i), .wr_i(wr_i), .addr_i(acc_addr_o), .cnt_o(cnt),
    .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .req_o(acc_req_o), .we_o(acc_we_o)
  );

  madb_pack u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i), .order_i(order_i),
    .cnt_i(cnt), .rd_ok_i(rd_ok), .wr_ok_i(wr_ok), .ad_i(ad_i),
    .rdata_i(acc_rdata_i), .ad_o(ad_o), .wdata_o(acc_wdata_o)
  );
endmodule

// File: rtl/madb_checker.sv
module madb_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dual_i,
  input logic              ale_lo_i,
  input logic              ale_hi_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [15:0]       ad_o,
  input logic              acc_req_o,
  input logic              acc_we_o,
  input logic [ADDR_W-1:0] acc_addr_o
);
  p_req_single_dir_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o |-> (rd_i ^ wr_i));

  p_we_follows_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o |-> (acc_we_o == wr_i));

  p_no_req_on_ale_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_lo_i |-> !acc_req_o);

  p_addr_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_lo_i && !ale_hi_i) |=> $stable(acc_addr_o));

  p_hi_ignored_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_i && !ale_lo_i) |=> $stable(acc_addr_o));

  p_ad_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(ad_o));
endmodule

bind madb_slave madb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dual_i(dual_i), .ale_lo_i(ale_lo_i),
  .ale_hi_i(ale_hi_i), .rd_i(rd_i), .wr_i(wr_i), .ad_o(ad_o),
  .acc_req_o(acc_req_o), .acc_we_o(acc_we_o), .acc_addr_o(acc_addr_o)
);

// File: tb/sim_madb_slave.sv
`timescale 1ns/1ps
module sim_madb_slave;
  localparam int AW = 12;
  localparam int FB = 16;
  localparam int FN = 4;
  localparam int HALF = AW / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide = 1'b1, dual = 1'b0;
  logic [1:0] order = 2'b00;
  logic ale_lo = 1'b0, ale_hi = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] ad = '0;
  logic [15:0] ad_out;
  logic acc_req, acc_we;
  logic [AW-1:0] acc_addr;
  logic [31:0] acc_wdata, acc_rdata;

  always #5 clk = ~clk;

  madb_slave #(.ADDR_W(AW), .FIFO_BASE(FB), .FIFO_NUM(FN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .dual_i(dual), .order_i(order),
    .ale_lo_i(ale_lo), .ale_hi_i(ale_hi), .rd_i(rd), .wr_i(wr), .ad_i(ad),
    .ad_o(ad_out), .acc_req_o(acc_req), .acc_we_o(acc_we), .acc_addr_o(acc_addr),
    .acc_wdata_o(acc_wdata), .acc_rdata_i(acc_rdata)
  );

  int errors = 0, checks = 0;
  int acc_cnt = 0;
  bit done = 0;
  string tag = "R1";
  logic [7:0] pops = 8'd0;

  assign acc_rdata = {8'hA0 + pops, 8'h3C, 4'h0, acc_addr};

  always @(posedge clk) begin
    if (acc_req && !acc_we) pops <= pops + 8'd1;
    if (acc_req) acc_cnt <= acc_cnt + 1;
  end

  // reference model state
  int m_addr = 0, m_idx = 0;
  bit m_armed = 0, m_dir_wr = 0;
  logic [7:0] mb [4];
  logic [7:0] rb [4];
  logic [15:0] m_ad = 16'h0;

  function automatic int pos(input int j);
    case (order)
      2'b01: return 3 - j;
      2'b10: return j ^ 2;
      default: return j;
    endcase
  endfunction

  function automatic bit in_fifo(input int a);
    return (a >= FB) && (a < FB + FN);
  endfunction

  function automatic int lanes();
    return wide ? 2 : 4;
  endfunction

  function automatic bit accepted();
    bit a;
    a = ale_lo | (dual & ale_hi);
    return m_armed && !a && (rd ^ wr) && (m_idx == 0 || m_dir_wr == wr);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_idx = 0; m_armed = 0; m_dir_wr = 0; m_ad = 16'h0;
      for (int j = 0; j < 4; j++) begin mb[j] = 8'h0; rb[j] = 8'h0; end
    end else if (ale_lo | (dual & ale_hi)) begin
      if (!dual) m_addr = ad % (1 << AW);
      else begin
        if (ale_lo) m_addr = (m_addr / (1 << HALF)) * (1 << HALF) + (ad % (1 << HALF));
        if (ale_hi) m_addr = (ad % (1 << (AW - HALF))) * (1 << HALF) + (m_addr % (1 << HALF));
      end
      m_idx = 0; m_armed = 1;
    end else if (accepted()) begin
      if (rd) begin
        if (m_idx == 0)
          for (int j = 0; j < 4; j++) rb[j] = acc_rdata[8*pos(j) +: 8];
        m_ad = wide ? {rb[2*m_idx+1], rb[2*m_idx]} : {8'h00, rb[m_idx]};
      end else begin
        if (wide) begin mb[2*m_idx] = ad[7:0]; mb[2*m_idx+1] = ad[15:8]; end
        else mb[m_idx] = ad[7:0];
      end
      m_dir_wr = wr;
      m_idx++;
      if (m_idx == lanes()) begin
        m_idx = 0;
        m_armed = in_fifo(m_addr);
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_req, e_we, ok;
      logic [7:0] tb [4];
      logic [31:0] e_wd;
      ok = accepted();
      e_req = ok && ((rd && m_idx == 0) || (wr && m_idx == lanes() - 1));
      e_we = e_req && wr;
      e_wd = '0;
      if (e_we) begin
        for (int j = 0; j < 4; j++) tb[j] = mb[j];
        if (wide) begin tb[2*m_idx] = ad[7:0]; tb[2*m_idx+1] = ad[15:8]; end
        else tb[m_idx] = ad[7:0];
        for (int j = 0; j < 4; j++) e_wd[8*pos(j) +: 8] = tb[j];
      end
      checks++;
      if (acc_req !== e_req || acc_we !== e_we || ad_out !== m_ad ||
          (e_req && acc_addr !== AW'(m_addr)) || (e_we && acc_wdata !== e_wd)) begin
        errors++;
        $display("FAIL %s t=%0t actual req=%0b we=%0b addr=%h wd=%h ad=%h expected req=%0b we=%0b addr=%h wd=%h ad=%h",
                 tag, $time, acc_req, acc_we, acc_addr, acc_wdata, ad_out,
                 e_req, e_we, AW'(m_addr), e_wd, m_ad);
      end
    end
  end

  task automatic cyc(input logic l, input logic h, input logic r, input logic w,
                     input logic [15:0] d);
    ale_lo = l; ale_hi = h; rd = r; wr = w; ad = d;
    @(posedge clk); #1;
    ale_lo = 0; ale_hi = 0; rd = 0; wr = 0;
  endtask

  task automatic count_check(input string t, input int base, input int exp_n);
    checks++;
    if (acc_cnt - base != exp_n) begin
      errors++;
      $display("FAIL %s access count actual=%0d expected=%0d", t, acc_cnt - base, exp_n);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;   // R1 reset state
    if (ad_out !== 16'h0 || acc_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual ad=%h req=%0b expected ad=0000 req=0", ad_out, acc_req);
    end
    @(posedge clk); #1;

    tag = "R1"; base = acc_cnt;
    cyc(0,0,0,1,16'h1111); cyc(0,0,0,1,16'h2222); cyc(0,0,1,0,0); cyc(0,0,0,0,0);
    count_check("R1", base, 0);

    tag = "R4"; wide = 1; dual = 0; order = 2'b00;
    cyc(1,0,0,0,16'h0123); cyc(0,0,0,1,16'hBEEF); cyc(0,0,0,1,16'hDEAD);
    tag = "R2";
    cyc(1,0,0,0,16'hF456); cyc(0,0,0,1,16'h0001); cyc(0,0,0,1,16'h0002);
    cyc(1,0,0,0,16'h0100); cyc(0,1,0,0,16'h003F); cyc(0,0,0,1,16'h0A0A); cyc(0,0,0,1,16'h0B0B);

    tag = "R5"; wide = 0;
    cyc(1,0,0,0,16'h00AB);
    cyc(0,0,0,1,16'hFF11); cyc(0,0,0,1,16'h0022); cyc(0,0,0,1,16'h0033); cyc(0,0,0,1,16'h0044);
    cyc(1,0,0,0,16'h00AC);
    for (int k = 0; k < 4; k++) cyc(0,0,1,0,0);

    tag = "R6"; wide = 1;
    cyc(1,0,0,0,16'h00C0); cyc(0,0,1,0,0); cyc(0,0,0,0,0); cyc(0,0,1,0,0); cyc(0,0,0,0,0);

    tag = "R7";
    for (int o = 1; o < 4; o++) begin
      order = 2'(o);
      for (int w = 0; w < 2; w++) begin
        wide = w[0];
        cyc(1,0,0,0,16'h0021 + 16'(o));
        for (int k = 0; k < 4 - 2*w; k++) cyc(0,0,0,1,16'h1122 + 16'(k * 16'h2222));
        cyc(1,0,0,0,16'h0031 + 16'(o));
        for (int k = 0; k < 4 - 2*w; k++) cyc(0,0,1,0,0);
      end
    end
    order = 2'b00; wide = 1;

    tag = "R3"; dual = 1;
    cyc(1,0,0,0,16'hFFD5); cyc(0,1,0,0,16'hFFEA); cyc(0,0,0,1,16'h5555); cyc(0,0,0,1,16'h6666);
    cyc(0,1,0,0,16'h0003); cyc(0,0,0,1,16'h7777); cyc(0,0,0,1,16'h8888);
    cyc(1,1,0,0,16'h0009); cyc(0,0,1,0,0); cyc(0,0,1,0,0);
    dual = 0;

    tag = "R8"; base = acc_cnt;
    cyc(1,0,0,0,16'h0050); cyc(0,0,0,1,16'hAAAA);
    cyc(1,0,0,0,16'h0051); cyc(0,0,0,1,16'h1111); cyc(0,0,0,1,16'h2222);
    count_check("R8", base, 1);

    tag = "R9"; base = acc_cnt;
    cyc(1,0,0,0,16'h0060); cyc(0,0,0,1,16'h1234); cyc(0,0,0,1,16'h5678);
    cyc(0,0,0,1,16'h9999); cyc(0,0,0,1,16'h9999); cyc(0,0,1,0,0); cyc(0,0,0,0,0);
    count_check("R9", base, 1);

    tag = "R10"; base = acc_cnt;
    cyc(1,0,0,0,16'd17);
    for (int k = 0; k < 6; k++) cyc(0,0,1,0,0);
    count_check("R10", base, 3);
    wide = 0; base = acc_cnt;
    cyc(1,0,0,0,16'd19);
    for (int k = 0; k < 8; k++) cyc(0,0,0,1,16'(8'h40 + k));
    count_check("R10", base, 2);
    cyc(1,0,0,0,16'd20); base = acc_cnt;
    for (int k = 0; k < 8; k++) cyc(0,0,0,1,16'(k));
    count_check("R10", base, 1);
    wide = 1;

    tag = "R11"; base = acc_cnt;
    cyc(1,0,0,0,16'h0070); cyc(0,0,1,1,16'hEEEE);
    cyc(0,0,0,1,16'h0F0F); cyc(0,0,1,0,0); cyc(0,0,0,1,16'hF0F0);
    count_check("R11", base, 1);

    cyc(0,0,0,0,0); cyc(0,0,0,0,0);
    done = 1;
    summary();
    $finish;
  end
endmodule